// File: doc/BRIEF.md
# Discontinuous Multilevel PWM Level Modulator

This block turns three phase voltage references, given in units of one dc cell (0 up to n−1 for an n-level leg), into per-phase level commands for a carrier-based discontinuous PWM scheme. Each reference is split into a lower level L and a fractional nominal signal between 0 and 1. The multilevel problem then becomes a virtual two-level problem per phase. The three nominal signals are ranked. From the two zero-state dwell times (K1 = 1 − max, K4 = min), a common offset is picked that clamps one phase to a rail of its own cell for the whole carrier period. This removes that phase's commutations.

A shared symmetric triangle carrier runs over the nominal range with a programmable step rate. At each carrier valley, the block latches the lower levels, the shifted nominal signals and the rank one-hots, and holds them for the whole period. During the period, each phase outputs L while its shifted signal is at or below the carrier and L+1 while it is above. When K1 and K4 are equal, the choice between them uses the distance of the resulting common mode from the dc midpoint, measured from a common-mode reference input.

Top module: `dpwm_level_mod`

## Requirements
- R1: While rst_n is low at a clock edge, all level outputs, both one-hot outputs and period_start are 0 after that edge, whatever the inputs are.
- R2: References are unsigned fixed point with FRAC_W fraction bits (default 6, so 64 = one cell; default n = 3). The lower level L is the integer part of the reference, except that a reference of exactly n−1 gives L = n−2. Each level output is always L or L+1 of the latched reference.
- R3: The nominal signal is the reference minus L·2^FRAC_W, in 0..2^FRAC_W. The carrier counts 0 up to 2^FRAC_W−1 and back down, with each value shown twice per period. A phase outputs L+1 exactly while its shifted nominal signal is strictly greater than the carrier value, so over one period it is high for 2·s carrier steps, where s is the shifted signal.
- R4: max_onehot and mid_onehot mark the phases holding the largest and the middle nominal signal (bit 0 = phase a, bit 1 = phase b, bit 2 = phase c). On equal values, the lower bit index ranks higher.
- R5: The offset added to all three nominal signals is +K1 when K1 < K4 and −K4 when K4 < K1. Here K1 = 2^FRAC_W − max and K4 = min. At least one phase is therefore constant over the period.
- R6: When K1 = K4, d1 = |cm + K1 − H| and d4 = ||cm − K4| − H| are formed, with H = (n−1)·2^FRAC_W/2 and cm the common-mode reference input. The offset is +K1 if d1 < d4, otherwise −K4.
- R7: References, common mode and the rank results are taken only at a carrier valley. Input changes within a period have no effect on the outputs until the next valley.
- R8: The carrier moves one step every carrier_div+1 clocks. A period is 2·2^FRAC_W steps. period_start is high for exactly one clock, the clock after each valley latch, and the first valley after reset is the first step.
- R9: A phase whose shifted signal is exactly 2^FRAC_W holds L+1 for the whole period, and one whose shifted signal is exactly 0 holds L, with no toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_div | input | DIV_W | Clocks per carrier step, minus one |
| ref_a | input | REF_W | Phase a reference, cell units, FRAC_W fraction bits |
| ref_b | input | REF_W | Phase b reference |
| ref_c | input | REF_W | Phase c reference |
| cm_ref | input | REF_W | Common-mode reference used for the tie-break |
| lvl_a | output | LVL_W | Phase a level command |
| lvl_b | output | LVL_W | Phase b level command |
| lvl_c | output | LVL_W | Phase c level command |
| max_onehot | output | 3 | Phase holding the largest nominal signal |
| mid_onehot | output | 3 | Phase holding the middle nominal signal |
| period_start | output | 1 | One-clock pulse after each valley latch |

## Verification
The bench targets references sitting exactly on the top level. A design that forgets the n−2 cap there would command a level beyond the rail and report a zero duty. It drives equal dwell times with common-mode values on both sides of the midpoint, and at the exact midpoint. A wrong tie-break or sign in d1 or d4 then shows up as the wrong phase being clamped high or low. Equal nominal signals exercise the rank one-hots: a sorter without a fixed index priority would flag two phases or none. Inputs change in the middle of each period and the step divider is changed, so a design that samples outside the valley, or miscounts the period, produces duty counts that do not match the expected values.

// File: rtl/dpwm_pkg.sv
// Shared constants and types for the discontinuous PWM level modulator.
package dpwm_pkg;
    // Number of phases handled by the modulator.
    localparam int NPH = 3;

    // Direction of the discontinuous offset: push the top phase to 1 or the
    // bottom phase to 0.
    typedef enum logic {
        OFS_UP   = 1'b0,
        OFS_DOWN = 1'b1
    } ofs_dir_t;
endpackage

// File: rtl/dpwm_tri_carrier.sv
// Symmetric triangle carrier over the nominal range.
// Counts 0 .. 2^FRAC_W-1 up, then 2^FRAC_W-1 .. 0 down, each end value held
// for one extra step, so a full period is 2*2^FRAC_W steps. A step happens
// every div+1 clocks. The valley strobe marks the step that leaves the last
// 0 of the down ramp; reset places the counter just before such a step.
// Assumes div is changed only at a valley if exact periods are wanted.
module dpwm_tri_carrier #(
    parameter int FRAC_W = 6,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    output logic [FRAC_W-1:0] cnt_o,
    output logic              valley_o,
    output logic              sync_o
);
    localparam logic [FRAC_W-1:0] CNT_TOP = '1;

    logic [DIV_W-1:0]  pre_q;
    logic [FRAC_W-1:0] cnt_q;
    logic              rising_q;
    logic              step;

    assign step     = (pre_q >= div_i);
    assign valley_o = step && !rising_q && (cnt_q == '0);
    assign cnt_o    = cnt_q;

    // Prescaler: counts clocks between carrier steps.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (step) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    // Triangle counter with direction flag; end values are repeated once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            rising_q <= 1'b0;
        end else if (step) begin
            if (rising_q) begin
                if (cnt_q == CNT_TOP) rising_q <= 1'b0;
                else                  cnt_q    <= cnt_q + 1'b1;
            end else begin
                if (cnt_q == '0) rising_q <= 1'b1;
                else             cnt_q    <= cnt_q - 1'b1;
            end
        end
    end

    // Period-start pulse: one clock after each valley step.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_o <= 1'b0;
        else        sync_o <= valley_o;
    end
endmodule

// File: rtl/dpwm_level_split.sv
// Splits one phase reference into its lower level and nominal signal.
// The lower level is the integer part, capped at N_LEVELS-2 so that the
// upper level stays valid; the nominal signal is the remainder, 0..2^FRAC_W.
// Assumes the reference does not exceed (N_LEVELS-1)*2^FRAC_W.
module dpwm_level_split #(
    parameter int N_LEVELS = 3,
    parameter int FRAC_W   = 6,
    parameter int LVL_W    = 2,
    parameter int REF_W    = 8
) (
    input  logic [REF_W-1:0]  ref_i,
    output logic [LVL_W-1:0]  lo_o,
    output logic [FRAC_W:0]   xi_o
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(N_LEVELS - 1);
    localparam logic [LVL_W-1:0] CAP_LVL = LVL_W'(N_LEVELS - 2);

    logic [LVL_W-1:0] intp;
    logic [REF_W-1:0] base;
    logic [REF_W-1:0] diff;

    // Integer part, capped below the top level, and the remainder.
    always_comb begin
        intp = ref_i[REF_W-1:FRAC_W];
        lo_o = (intp >= TOP_LVL) ? CAP_LVL : intp;
        base = {lo_o, {FRAC_W{1'b0}}};
        diff = ref_i - base;
        xi_o = diff[FRAC_W:0];
    end
endmodule

// File: rtl/dpwm_rank3.sv
// Ranks the three nominal signals. Produces the largest and smallest values
// and one-hot markers for the largest and middle phases. On equal values the
// lower phase index ranks higher, so exactly one phase holds each rank.
module dpwm_rank3 #(
    parameter int XW = 7
) (
    input  logic [XW-1:0]              xi_i [dpwm_pkg::NPH],
    output logic [XW-1:0]              vmax_o,
    output logic [XW-1:0]              vmin_o,
    output logic [dpwm_pkg::NPH-1:0]   oh_max_o,
    output logic [dpwm_pkg::NPH-1:0]   oh_mid_o
);
    import dpwm_pkg::*;

    logic [1:0] rank [NPH];

    // Rank of each phase: number of phases that beat it.
    always_comb begin
        for (int i = 0; i < NPH; i++) begin
            rank[i] = 2'd0;
            for (int j = 0; j < NPH; j++) begin
                if (j != i) begin
                    if ((xi_i[j] > xi_i[i]) || ((xi_i[j] == xi_i[i]) && (j < i)))
                        rank[i] = rank[i] + 2'd1;
                end
            end
        end
    end

    // Select extreme values and rank markers from the ranks.
    always_comb begin
        vmax_o   = '0;
        vmin_o   = '0;
        oh_max_o = '0;
        oh_mid_o = '0;
        for (int i = 0; i < NPH; i++) begin
            if (rank[i] == 2'd0) begin
                vmax_o      = xi_i[i];
                oh_max_o[i] = 1'b1;
            end
            if (rank[i] == 2'd1) oh_mid_o[i] = 1'b1;
            if (rank[i] == 2'd2) vmin_o = xi_i[i];
        end
    end
endmodule

// File: rtl/dpwm_offset_pick.sv
// Chooses the discontinuous offset from the two zero-state dwell times.
// K1 = 2^FRAC_W - max, K4 = min. The smaller dwell is removed; on a tie the
// choice keeps the resulting common mode nearer the dc midpoint H.
module dpwm_offset_pick #(
    parameter int N_LEVELS = 3,
    parameter int FRAC_W   = 6,
    parameter int REF_W    = 8
) (
    input  logic [FRAC_W:0]          vmax_i,
    input  logic [FRAC_W:0]          vmin_i,
    input  logic [REF_W-1:0]         cm_i,
    output logic signed [FRAC_W+1:0] ofs_o
);
    import dpwm_pkg::*;

    localparam int SW = REF_W + 3;
    localparam logic signed [SW-1:0] ONE_S  = SW'(1 << FRAC_W);
    localparam logic signed [SW-1:0] HALF_S = SW'(((N_LEVELS - 1) * (1 << FRAC_W)) / 2);

    logic signed [SW-1:0] k1, k4, cm_s, d1, d4, pick;
    ofs_dir_t             dir;

    function automatic logic signed [SW-1:0] mag(input logic signed [SW-1:0] v);
        return (v < 0) ? -v : v;
    endfunction

    // Dwell times, midpoint distances and the resulting choice.
    always_comb begin
        k1   = ONE_S - $signed(SW'(vmax_i));
        k4   = $signed(SW'(vmin_i));
        cm_s = $signed(SW'(cm_i));
        d1   = mag(cm_s + k1 - HALF_S);
        d4   = mag(mag(cm_s - k4) - HALF_S);
        if (k1 < k4)      dir = OFS_UP;
        else if (k4 < k1) dir = OFS_DOWN;
        else if (d1 < d4) dir = OFS_UP;
        else              dir = OFS_DOWN;
        pick  = (dir == OFS_UP) ? k1 : -k4;
        ofs_o = pick[FRAC_W+1:0];
    end
endmodule

// File: rtl/dpwm_level_mod.sv
// Top of the discontinuous multilevel PWM level modulator.
// Decomposes three references into lower level and nominal signal, ranks the
// nominal signals, adds the discontinuous offset, latches the result at each
// carrier valley and compares it with the shared triangle to command L or L+1.
// Assumes references and cm_ref lie in 0..(N_LEVELS-1)*2^FRAC_W, N_LEVELS >= 2,
// FRAC_W >= 1.
module dpwm_level_mod #(
    parameter  int N_LEVELS = 3,
    parameter  int FRAC_W   = 6,
    parameter  int DIV_W    = 8,
    localparam int LVL_W    = $clog2(N_LEVELS),
    localparam int REF_W    = LVL_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] carrier_div,
    input  logic [REF_W-1:0] ref_a,
    input  logic [REF_W-1:0] ref_b,
    input  logic [REF_W-1:0] ref_c,
    input  logic [REF_W-1:0] cm_ref,
    output logic [LVL_W-1:0] lvl_a,
    output logic [LVL_W-1:0] lvl_b,
    output logic [LVL_W-1:0] lvl_c,
    output logic [2:0]       max_onehot,
    output logic [2:0]       mid_onehot,
    output logic             period_start
);
    import dpwm_pkg::*;

    localparam int XW = FRAC_W + 1;

    logic [REF_W-1:0]         ref_v [NPH];
    logic [LVL_W-1:0]         lo_w  [NPH];
    logic [XW-1:0]            xi_w  [NPH];
    logic [XW-1:0]            shf_w [NPH];
    logic [LVL_W-1:0]         lo_q  [NPH];
    logic [XW-1:0]            shf_q [NPH];
    logic [LVL_W-1:0]         lvl_w [NPH];
    logic [XW-1:0]            vmax, vmin;
    logic [NPH-1:0]           oh_max_w, oh_mid_w;
    logic [NPH-1:0]           max_q, mid_q;
    logic signed [FRAC_W+1:0] ofs;
    logic [FRAC_W-1:0]        carrier_q;
    logic                     valley;

    assign ref_v[0] = ref_a;
    assign ref_v[1] = ref_b;
    assign ref_v[2] = ref_c;

    dpwm_tri_carrier #(.FRAC_W(FRAC_W), .DIV_W(DIV_W)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_i    (carrier_div),
        .cnt_o    (carrier_q),
        .valley_o (valley),
        .sync_o   (period_start)
    );

    dpwm_rank3 #(.XW(XW)) u_rank (
        .xi_i     (xi_w),
        .vmax_o   (vmax),
        .vmin_o   (vmin),
        .oh_max_o (oh_max_w),
        .oh_mid_o (oh_mid_w)
    );

    dpwm_offset_pick #(.N_LEVELS(N_LEVELS), .FRAC_W(FRAC_W), .REF_W(REF_W)) u_ofs (
        .vmax_i (vmax),
        .vmin_i (vmin),
        .cm_i   (cm_ref),
        .ofs_o  (ofs)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        logic signed [FRAC_W+2:0] sum;

        dpwm_level_split #(
            .N_LEVELS (N_LEVELS),
            .FRAC_W   (FRAC_W),
            .LVL_W    (LVL_W),
            .REF_W    (REF_W)
        ) u_split (
            .ref_i (ref_v[p]),
            .lo_o  (lo_w[p]),
            .xi_o  (xi_w[p])
        );

        // Shifted nominal signal; the offset range keeps it in 0..2^FRAC_W.
        always_comb begin
            sum      = $signed({2'b00, xi_w[p]}) + $signed({ofs[FRAC_W+1], ofs});
            shf_w[p] = sum[FRAC_W:0];
        end

        // Hold the phase state from one valley to the next.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[p]  <= '0;
                shf_q[p] <= '0;
            end else if (valley) begin
                lo_q[p]  <= lo_w[p];
                shf_q[p] <= shf_w[p];
            end
        end

        // Level command: upper level while the signal is above the carrier.
        always_comb begin
            lvl_w[p] = lo_q[p] + LVL_W'(shf_q[p] > {1'b0, carrier_q});
        end
    end

    // Hold the rank markers from one valley to the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q <= '0;
            mid_q <= '0;
        end else if (valley) begin
            max_q <= oh_max_w;
            mid_q <= oh_mid_w;
        end
    end

    assign lvl_a      = lvl_w[0];
    assign lvl_b      = lvl_w[1];
    assign lvl_c      = lvl_w[2];
    assign max_onehot = max_q;
    assign mid_onehot = mid_q;
endmodule

// File: rtl/dpwm_level_mod_chk.sv
// Property checker for the level modulator, bound into every instance.
// Watches the level outputs, rank markers, carrier and latched shifted signals.
module dpwm_level_mod_chk #(
    parameter  int N_LEVELS = 3,
    parameter  int FRAC_W   = 6,
    localparam int LVL_W    = $clog2(N_LEVELS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  lvl_a,
    input logic [LVL_W-1:0]  lvl_b,
    input logic [LVL_W-1:0]  lvl_c,
    input logic [2:0]        max_onehot,
    input logic [2:0]        mid_onehot,
    input logic              period_start,
    input logic [FRAC_W-1:0] carrier,
    input logic [FRAC_W:0]   shf [3]
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(N_LEVELS - 1);
    localparam logic [FRAC_W:0]  ONE     = (FRAC_W+1)'(1 << FRAC_W);

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_a <= TOP_LVL) && (lvl_b <= TOP_LVL) && (lvl_c <= TOP_LVL)); // R2

    AST_RANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(max_onehot) && $onehot0(mid_onehot) && ((max_onehot & mid_onehot) == 3'b000)); // R4

    AST_ONE_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> ((shf[0] == '0) || (shf[0] == ONE) || (shf[1] == '0) ||
                          (shf[1] == ONE) || (shf[2] == '0) || (shf[2] == ONE))); // R5

    AST_HOLD_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |-> ($stable(max_onehot) && $stable(mid_onehot))); // R7

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start); // R8

    AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (({1'b0, carrier} == {1'b0, $past(carrier)}) ||
                   ({1'b0, carrier} == {1'b0, $past(carrier)} + 1'b1) ||
                   ({1'b0, carrier} + 1'b1 == {1'b0, $past(carrier)}))); // R8
endmodule

bind dpwm_level_mod dpwm_level_mod_chk #(.N_LEVELS(N_LEVELS), .FRAC_W(FRAC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lvl_a        (lvl_a),
    .lvl_b        (lvl_b),
    .lvl_c        (lvl_c),
    .max_onehot   (max_onehot),
    .mid_onehot   (mid_onehot),
    .period_start (period_start),
    .carrier      (carrier_q),
    .shf          (shf_q)
);

// File: tb/sim_dpwm_level_mod.sv
// Self-checking bench: a vector table walked one carrier period per vector,
// then directed tests for the step divider and a mid-run reset.
module sim_dpwm_level_mod;
    localparam int CLK_PERIOD = 10;
    localparam int NL    = 3;
    localparam int FW    = 6;
    localparam int DW    = 8;
    localparam int LW    = $clog2(NL);
    localparam int RW    = LW + FW;
    localparam int ONE   = 1 << FW;
    localparam int HALF  = ((NL - 1) * ONE) / 2;
    localparam int NV    = 14;
    // Each row: ref_a, ref_b, ref_c, cm_ref
    localparam int VEC [NV][4] = '{
        '{ 96,  40,  20,  60},
        '{128,  64,  10,  64},
        '{ 50,  30,  14,  64},
        '{ 50,  30,  14, 100},
        '{ 50,  30,  14,  20},
        '{ 50,  30,  14,   0},
        '{ 50,  30,  14,  10},
        '{ 30,  30,  30,  40},
        '{ 10,  50,  50,  30},
        '{  0,   0,   0,   0},
        '{128, 128, 128, 128},
        '{127,   1,  64,  64},
        '{ 70, 100,   5,  58},
        '{114,  94,  78,  10}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] carrier_div;
    logic [RW-1:0] ref_a, ref_b, ref_c, cm_ref;
    logic [LW-1:0] lvl_a, lvl_b, lvl_c;
    logic [2:0]    max_onehot, mid_onehot;
    logic          period_start;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  cyc    = 0;
    bit  done   = 1'b0;
    int  exp_lo [3];
    int  exp_xs [3];
    int  exp_mx, exp_md;
    bit  exp_tie;

    dpwm_level_mod #(.N_LEVELS(NL), .FRAC_W(FW), .DIV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .carrier_div(carrier_div),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .cm_ref(cm_ref),
        .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c),
        .max_onehot(max_onehot), .mid_onehot(mid_onehot),
        .period_start(period_start)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run is one failed check and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog actual=%0d expected<=%0d cycles", cyc, 60000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lvl_of(input int p);
        case (p)
            0:       return int'(lvl_a);
            1:       return int'(lvl_b);
            default: return int'(lvl_c);
        endcase
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Expected behaviour from the requirements (R2 R3 R4 R5 R6).
    task automatic model(input int row);
        int xi [3];
        int vmax, vmin, k1, k4, ofs, d1, d4;
        vmax = 0; vmin = 0; exp_mx = 0; exp_md = 0;
        for (int p = 0; p < 3; p++) begin
            exp_lo[p] = VEC[row][p] / ONE;
            if (exp_lo[p] >= NL - 1) exp_lo[p] = NL - 2;
            xi[p] = VEC[row][p] - exp_lo[p] * ONE;
        end
        for (int i = 0; i < 3; i++) begin
            int rk = 0;
            for (int j = 0; j < 3; j++)
                if (j != i && (xi[j] > xi[i] || (xi[j] == xi[i] && j < i))) rk++;
            if (rk == 0) begin exp_mx |= (1 << i); vmax = xi[i]; end
            if (rk == 1) exp_md |= (1 << i);
            if (rk == 2) vmin = xi[i];
        end
        k1 = ONE - vmax;
        k4 = vmin;
        exp_tie = (k1 == k4);
        if (k1 < k4)      ofs = k1;
        else if (k4 < k1) ofs = -k4;
        else begin
            d1  = iabs(VEC[row][3] + k1 - HALF);
            d4  = iabs(iabs(VEC[row][3] - k4) - HALF);
            ofs = (d1 < d4) ? k1 : -k4;
        end
        for (int p = 0; p < 3; p++) exp_xs[p] = xi[p] + ofs;
    endtask

    task automatic apply(input int row);
        ref_a  = RW'(VEC[row][0]);
        ref_b  = RW'(VEC[row][1]);
        ref_c  = RW'(VEC[row][2]);
        cm_ref = RW'(VEC[row][3]);
    endtask

    // Called at the negedge that opens a period; observes the whole period.
    task automatic measure(input int wlen, input int mult);
        int hi [3];
        int bad [3];
        int syncs, clamped, mx0, md0;
        syncs = 0; clamped = 0;
        mx0 = int'(max_onehot); md0 = int'(mid_onehot);
        for (int p = 0; p < 3; p++) begin hi[p] = 0; bad[p] = 0; end
        for (int k = 0; k < wlen; k++) begin
            if (k > 0) @(negedge clk);
            if (k > 0 && period_start) syncs++;
            for (int p = 0; p < 3; p++) begin
                if (lvl_of(p) == exp_lo[p] + 1)  hi[p]++;
                else if (lvl_of(p) != exp_lo[p]) bad[p]++;
            end
            if (k == wlen / 2) begin
                check("R7 max_onehot held within period", int'(max_onehot), mx0);
                check("R7 mid_onehot held within period", int'(mid_onehot), md0);
            end
        end
        check("R4 max_onehot", mx0, exp_mx);
        check("R4 mid_onehot", md0, exp_md);
        for (int p = 0; p < 3; p++) begin
            check("R2 level outside L..L+1", bad[p], 0);
            if (exp_tie)
                check("R6 tie-break duty", hi[p], 2 * exp_xs[p] * mult);
            else if (exp_xs[p] == 0 || exp_xs[p] == ONE)
                check("R9 clamped phase duty", hi[p], 2 * exp_xs[p] * mult);
            else
                check("R3 duty count", hi[p], 2 * exp_xs[p] * mult);
            if (hi[p] == 0 || hi[p] == wlen) clamped++;
        end
        check("R5 some phase constant", int'(clamped > 0), 1);
        check("R8 no extra period_start", syncs, 0);
        @(negedge clk);
        check("R8 period_start at period end", int'(period_start), 1);
    endtask

    initial begin
        rst_n       = 1'b0;
        carrier_div = '0;
        apply(0);
        repeat (3) @(negedge clk);
        // R1: reset state with non-zero inputs applied
        check("R1 lvl_a in reset", int'(lvl_a), 0);
        check("R1 lvl_b in reset", int'(lvl_b), 0);
        check("R1 lvl_c in reset", int'(lvl_c), 0);
        check("R1 max_onehot in reset", int'(max_onehot), 0);
        check("R1 period_start in reset", int'(period_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: first step after reset is a valley
        check("R8 first period_start after reset", int'(period_start), 1);

        // Table walk; the next row is applied at once, mid-period (R7).
        for (int i = 0; i < NV; i++) begin
            model(i);
            apply((i + 1 < NV) ? i + 1 : i);
            measure(2 * ONE, 1);
        end

        // Divider: two clocks per carrier step doubles every count (R8).
        carrier_div = DW'(1);
        model(NV - 1);
        measure(4 * ONE, 2);

        // Reset in the middle of a period clears everything (R1).
        carrier_div = '0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 lvl_a after mid-run reset", int'(lvl_a), 0);
        check("R1 lvl_c after mid-run reset", int'(lvl_c), 0);
        check("R1 mid_onehot after mid-run reset", int'(mid_onehot), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule